// File: doc/BRIEF.md
# Shared-Enable NAND Volume Selector

This block sits at the host-facing edge of a managed NAND package. Several such packages hang on one 8-bit asynchronous NAND bus and share a single active-low chip enable. Each package is given a small volume number once after power-up, through strap pins. The host then picks one package by issuing a dedicated volume-select command byte followed by a single address byte that carries the target number.

The block samples the bus pins (enable, command latch, address latch, write strobe, data) into the local clock domain through a synchronizer chain. It detects the rising edge of the write strobe and classifies the cycle as a command or an address byte. It keeps a sticky "selected" flag and forwards only those bus cycles that the package core behind it should act on. It also gates the package's data-pin output enable, so that only the selected package ever drives the shared data lines.

Top module: `nand_volsel_top`

## Requirements
- R1: The volume number is taken from `strap_vol` on the first clock after `rst_n` deasserts and is held until the next `rst_n` assertion. Later strap changes and bus reset commands (FFh) do not alter it.
- R2: After reset and before any volume-select, the package is unselected, unless `DEF_SEL0`=1 and the strapped number is 0, in which case it starts selected.
- R3: A command byte equal to `VS_OP` (default E1h) arms a selection. The next address byte then selects the package if its low `VOL_W` (default 4) bits equal the volume number, and the upper bits of that byte are ignored.
- R4: Selection is sticky. Commands and addresses other than a completed volume-select never change `vol_sel`, including the bus reset command.
- R5: A completed volume-select whose low bits name a different volume clears `vol_sel`.
- R6: A bus cycle is taken only on a rising edge of `bus_we_n` while `bus_ce_n` is low and exactly one of `bus_cle` (command) and `bus_ale` (address) is high. Edges with `bus_ce_n` high are ignored.
- R7: `dq_oe` is high only when the package is selected and both `bus_ce_n` and `bus_re_n` are low. An unselected package never drives the data pins.
- R8: While selected, every command except `VS_OP` raises `fwd_cmd_vld` with the byte on `fwd_byte`, and every address byte that is not consumed by a volume-select raises `fwd_addr_vld`. While unselected, only the `RST_OP` command (default FFh) is forwarded. The volume-select command and its address byte are never forwarded.
- R9: `sel_chg` pulses for one clock each time a bus volume-select flips `vol_sel`, and stays low when the flag keeps its value.
- R10: A command arriving while a volume-select waits for its address cancels the pending select. That command is handled as an ordinary command, and the following address byte is treated as an ordinary address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| strap_vol | input | VOL_W | Volume number straps |
| bus_ce_n | input | 1 | Shared active-low chip enable |
| bus_cle | input | 1 | Command latch enable |
| bus_ale | input | 1 | Address latch enable |
| bus_we_n | input | 1 | Active-low write strobe, latched on its rising edge |
| bus_re_n | input | 1 | Active-low read strobe |
| bus_dq | input | DQ_W | Data/command/address byte from the host |
| vol_sel | output | 1 | Package currently selected |
| sel_chg | output | 1 | One-clock pulse when the selection flips |
| fwd_cmd_vld | output | 1 | Forwarded command byte valid |
| fwd_addr_vld | output | 1 | Forwarded address byte valid |
| fwd_byte | output | DQ_W | Forwarded byte |
| dq_oe | output | 1 | Output enable for the package data drivers |

## Verification
A wrong selection flag shows up on the shared bus at once. A package that believes itself selected raises `dq_oe` on the very next read strobe, which contends with the true owner. A package that wrongly believes itself unselected drops the host's commands, and the forwarded-cycle stream runs short within one bus cycle. A corrupted armed state shows up one address byte later. Either a plain address is swallowed, or a stray address byte flips `vol_sel` and pulses `sel_chg`. Running several instances with different straps on one bus means any such error leaves either zero or two selected packages, which the checks catch at once.

// File: rtl/nand_volsel_pkg.sv
package nand_volsel_pkg;
   typedef enum logic [0:0] {
      VS_IDLE      = 1'b0,
      VS_WAIT_ADDR = 1'b1
   } vs_state_t;

   typedef struct packed {
      logic       is_cmd;
      logic       is_addr;
      logic [7:0] data;
   } bus_cycle_t;
endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
   import nand_volsel_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DQ_W        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic            cle,
   input  logic            ale,
   input  logic            we_n,
   input  logic [DQ_W-1:0] dq,
   output logic            cyc_stb,
   output bus_cycle_t      cyc
);
   localparam int W = DQ_W + 4;
   localparam logic [W-1:0] IDLE_VAL = {1'b1, 1'b1, 2'b00, {DQ_W{1'b0}}};

   logic [W-1:0] pipe [SYNC_STAGES];
   logic         we_last;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= IDLE_VAL;
               else        pipe[0] <= {we_n, ce_n, cle, ale, dq};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= IDLE_VAL;
               else        pipe[g] <= pipe[g-1];
            end
         end
      end
   endgenerate

   logic [W-1:0] last;
   assign last = pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_last <= 1'b1;
      else        we_last <= last[W-1];
   end

   logic s_ce_n, s_cle, s_ale;
   assign s_ce_n = last[W-2];
   assign s_cle  = last[W-3];
   assign s_ale  = last[W-4];

   always_comb begin
      cyc         = '0;
      cyc.is_cmd  = s_cle & ~s_ale;
      cyc.is_addr = s_ale & ~s_cle;
      cyc.data    = 8'(last[DQ_W-1:0]);
      cyc_stb     = last[W-1] & ~we_last & ~s_ce_n & (s_cle ^ s_ale);
   end
endmodule

// File: rtl/nand_vol_strap.sv
module nand_vol_strap #(
   parameter int VOL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VOL_W-1:0] strap,
   output logic [VOL_W-1:0] vol_id,
   output logic             vol_ready,
   output logic             load_stb
);
   assign load_stb = ~vol_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_id    <= '0;
         vol_ready <= 1'b0;
      end else if (load_stb) begin
         vol_id    <= strap;
         vol_ready <= 1'b1;
      end
   end
endmodule

// File: rtl/nand_vol_fsm.sv
module nand_vol_fsm
   import nand_volsel_pkg::*;
#(
   parameter int              VOL_W    = 4,
   parameter int              DQ_W     = 8,
   parameter logic [DQ_W-1:0] VS_OP    = 8'hE1,
   parameter logic [DQ_W-1:0] RST_OP   = 8'hFF,
   parameter bit              DEF_SEL0 = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_stb,
   input  bus_cycle_t       cyc,
   input  logic [VOL_W-1:0] vol_id,
   input  logic             strap_load,
   input  logic [VOL_W-1:0] strap_val,
   output logic             vol_sel,
   output logic             sel_chg,
   output logic             fwd_cmd_vld,
   output logic             fwd_addr_vld,
   output logic [DQ_W-1:0]  fwd_byte
);
   vs_state_t       state;
   logic            hit;
   logic [DQ_W-1:0] byte_in;

   assign byte_in = DQ_W'(cyc.data);
   assign hit     = (cyc.data[VOL_W-1:0] == vol_id);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= VS_IDLE;
         vol_sel      <= 1'b0;
         sel_chg      <= 1'b0;
         fwd_cmd_vld  <= 1'b0;
         fwd_addr_vld <= 1'b0;
         fwd_byte     <= '0;
      end else begin
         sel_chg      <= 1'b0;
         fwd_cmd_vld  <= 1'b0;
         fwd_addr_vld <= 1'b0;
         if (strap_load) begin
            vol_sel <= DEF_SEL0 && (strap_val == '0);
         end else if (cyc_stb) begin
            if (cyc.is_cmd) begin
               if (byte_in == VS_OP) begin
                  state <= VS_WAIT_ADDR;
               end else begin
                  state <= VS_IDLE;
                  if (vol_sel || byte_in == RST_OP) begin
                     fwd_cmd_vld <= 1'b1;
                     fwd_byte    <= byte_in;
                  end
               end
            end else if (state == VS_WAIT_ADDR) begin
               state   <= VS_IDLE;
               vol_sel <= hit;
               sel_chg <= (hit != vol_sel);
            end else if (vol_sel) begin
               fwd_addr_vld <= 1'b1;
               fwd_byte     <= byte_in;
            end
         end
      end
   end
endmodule

// File: rtl/nand_volsel_top.sv
module nand_volsel_top
   import nand_volsel_pkg::*;
#(
   parameter int              VOL_W       = 4,
   parameter int              DQ_W        = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [DQ_W-1:0] VS_OP       = 8'hE1,
   parameter logic [DQ_W-1:0] RST_OP      = 8'hFF,
   parameter bit              DEF_SEL0    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VOL_W-1:0] strap_vol,
   input  logic             bus_ce_n,
   input  logic             bus_cle,
   input  logic             bus_ale,
   input  logic             bus_we_n,
   input  logic             bus_re_n,
   input  logic [DQ_W-1:0]  bus_dq,
   output logic             vol_sel,
   output logic             sel_chg,
   output logic             fwd_cmd_vld,
   output logic             fwd_addr_vld,
   output logic [DQ_W-1:0]  fwd_byte,
   output logic             dq_oe
);
   if (VOL_W < 1 || VOL_W > DQ_W) begin : g_bad_vol
      $error("VOL_W must lie in 1..DQ_W");
   end
   if (DQ_W != 8) begin : g_bad_dq
      $error("DQ_W must be 8 for the asynchronous bus");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             cyc_stb;
   bus_cycle_t       cyc;
   logic [VOL_W-1:0] vol_id;
   logic             vol_ready;
   logic             strap_load;

   nand_bus_sampler #(.SYNC_STAGES(SYNC_STAGES), .DQ_W(DQ_W)) i_sampler (
      .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .cle(bus_cle), .ale(bus_ale),
      .we_n(bus_we_n), .dq(bus_dq), .cyc_stb(cyc_stb), .cyc(cyc)
   );

   nand_vol_strap #(.VOL_W(VOL_W)) i_strap (
      .clk(clk), .rst_n(rst_n), .strap(strap_vol), .vol_id(vol_id),
      .vol_ready(vol_ready), .load_stb(strap_load)
   );

   nand_vol_fsm #(
      .VOL_W(VOL_W), .DQ_W(DQ_W), .VS_OP(VS_OP), .RST_OP(RST_OP), .DEF_SEL0(DEF_SEL0)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cyc(cyc), .vol_id(vol_id),
      .strap_load(strap_load), .strap_val(strap_vol), .vol_sel(vol_sel),
      .sel_chg(sel_chg), .fwd_cmd_vld(fwd_cmd_vld), .fwd_addr_vld(fwd_addr_vld),
      .fwd_byte(fwd_byte)
   );

   assign dq_oe = vol_sel & ~bus_ce_n & ~bus_re_n;
endmodule

// File: rtl/nand_volsel_chk.sv
module nand_volsel_chk #(
   parameter int              VOL_W = 4,
   parameter int              DQ_W  = 8,
   parameter logic [DQ_W-1:0] VS_OP = 8'hE1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vol_sel,
   input logic             sel_chg,
   input logic             fwd_cmd_vld,
   input logic             fwd_addr_vld,
   input logic [DQ_W-1:0]  fwd_byte,
   input logic             dq_oe,
   input logic [VOL_W-1:0] vol_id,
   input logic             vol_ready
);
   AST_VOL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_ready && $past(vol_ready)) |-> $stable(vol_id)); // R1
   AST_CHG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      sel_chg |-> (vol_sel != $past(vol_sel))); // R9
   AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> vol_sel); // R7
   AST_NO_VS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_cmd_vld |-> (fwd_byte != VS_OP)); // R8
   AST_ADDR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_addr_vld |-> vol_sel); // R8
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_cmd_vld, fwd_addr_vld, sel_chg})); // R10
endmodule

bind nand_volsel_top nand_volsel_chk #(.VOL_W(VOL_W), .DQ_W(DQ_W), .VS_OP(VS_OP)) i_chk (
   .clk(clk), .rst_n(rst_n), .vol_sel(vol_sel), .sel_chg(sel_chg),
   .fwd_cmd_vld(fwd_cmd_vld), .fwd_addr_vld(fwd_addr_vld), .fwd_byte(fwd_byte),
   .dq_oe(dq_oe), .vol_id(vol_id), .vol_ready(vol_ready)
);

// File: tb/test_nand_volsel_top.sv
module test_nand_volsel_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] strap_a = 4'd5;
   logic       ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
   logic [7:0] dq = 8'h00;

   always #2.5 clk = ~clk;

   logic       sel_a, chg_a, cmd_a, adr_a, oe_a;
   logic [7:0] byte_a;
   logic       sel_b, chg_b, cmd_b, adr_b, oe_b;
   logic [7:0] byte_b;
   logic       sel_c, chg_c, cmd_c, adr_c, oe_c;
   logic [7:0] byte_c;

   nand_volsel_top i_nand_volsel_top (
      .clk(clk), .rst_n(rst_n), .strap_vol(strap_a), .bus_ce_n(ce_n), .bus_cle(cle),
      .bus_ale(ale), .bus_we_n(we_n), .bus_re_n(re_n), .bus_dq(dq), .vol_sel(sel_a),
      .sel_chg(chg_a), .fwd_cmd_vld(cmd_a), .fwd_addr_vld(adr_a), .fwd_byte(byte_a),
      .dq_oe(oe_a));
   nand_volsel_top #(.DEF_SEL0(1'b1)) i_nand_volsel_top_b (
      .clk(clk), .rst_n(rst_n), .strap_vol(4'd0), .bus_ce_n(ce_n), .bus_cle(cle),
      .bus_ale(ale), .bus_we_n(we_n), .bus_re_n(re_n), .bus_dq(dq), .vol_sel(sel_b),
      .sel_chg(chg_b), .fwd_cmd_vld(cmd_b), .fwd_addr_vld(adr_b), .fwd_byte(byte_b),
      .dq_oe(oe_b));
   nand_volsel_top i_nand_volsel_top_c (
      .clk(clk), .rst_n(rst_n), .strap_vol(4'd15), .bus_ce_n(ce_n), .bus_cle(cle),
      .bus_ale(ale), .bus_we_n(we_n), .bus_re_n(re_n), .bus_dq(dq), .vol_sel(sel_c),
      .sel_chg(chg_c), .fwd_cmd_vld(cmd_c), .fwd_addr_vld(adr_c), .fwd_byte(byte_c),
      .dq_oe(oe_c));

   typedef struct packed { logic is_addr; logic [7:0] b; } exp_t;
   exp_t exp_q[$];
   int   n_chk = 0, n_fail = 0, chg_cnt = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected forwarded items from the scoreboard (R8)
   always @(negedge clk) begin
      if (rst_n) begin
         if (chg_a) chg_cnt++;
         if (cmd_a || adr_a) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected forward", {23'd0, adr_a, byte_a}, 32'hFFFF_FFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R8 forwarded item", {23'd0, adr_a, byte_a}, {23'd0, e.is_addr, e.b});
            end
         end
      end
   end

   task automatic bus_cycle(input logic c, input logic a, input logic [7:0] d,
                            input logic ce, input logic fwd);
      @(negedge clk);
      ce_n = ce; cle = c; ale = a; dq = d; we_n = 1'b0;
      repeat (3) @(negedge clk);
      we_n = 1'b1;
      if (fwd) exp_q.push_back({a, d});
      repeat (6) @(negedge clk);
      cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic vsel(input logic [7:0] v);
      bus_cycle(1'b1, 1'b0, 8'hE1, 1'b0, 1'b0);
      bus_cycle(1'b0, 1'b1, v, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      check("R8 scoreboard drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R2 reset unselected", sel_a, 0);
      check("R2 default volume 0 selected", sel_b, 1);
      check("R2 strap 15 unselected", sel_c, 0);
      // unselected: ordinary command dropped, bus reset forwarded
      bus_cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
      bus_cycle(1'b1, 1'b0, 8'hFF, 1'b0, 1'b1);
      check("R4 bus reset keeps unselected", sel_a, 0);
      // read strobe while unselected
      ce_n = 1'b0; re_n = 1'b0; #1;
      check("R7 unselected no oe", oe_a, 0);
      check("R7 selected oe", oe_b, 1);
      ce_n = 1'b1; re_n = 1'b1;
      // select volume 5
      vsel(8'h05);
      check("R3 select volume 5", sel_a, 1);
      check("R5 other deselected", sel_b, 0);
      check("R9 one change pulse", chg_cnt, 1);
      // selected traffic is forwarded and selection sticks
      bus_cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
      bus_cycle(1'b0, 1'b1, 8'h12, 1'b0, 1'b1);
      bus_cycle(1'b1, 1'b0, 8'h30, 1'b0, 1'b1);
      bus_cycle(1'b1, 1'b0, 8'hFF, 1'b0, 1'b1);
      check("R4 sticky after commands", sel_a, 1);
      check("R1 bus reset keeps volume", sel_c, 0);
      ce_n = 1'b0; re_n = 1'b0; #1;
      check("R7 selected drives", oe_a, 1);
      check("R7 single driver b", oe_b, 0);
      ce_n = 1'b1; re_n = 1'b1; #1;
      check("R7 ce high no oe", oe_a, 0);
      // upper nibble ignored, re-select same volume: no change pulse
      vsel(8'hF5);
      check("R3 upper bits ignored", sel_a, 1);
      check("R9 no pulse on same value", chg_cnt, 1);
      check("R3 F5 does not pick 15", sel_c, 0);
      // cycles with chip enable high are ignored
      bus_cycle(1'b1, 1'b0, 8'hE1, 1'b1, 1'b0);
      bus_cycle(1'b0, 1'b1, 8'h0F, 1'b1, 1'b0);
      check("R6 ce high ignored a", sel_a, 1);
      check("R6 ce high ignored c", sel_c, 0);
      // pending select cancelled by a new command
      bus_cycle(1'b1, 1'b0, 8'hE1, 1'b0, 1'b0);
      bus_cycle(1'b1, 1'b0, 8'h70, 1'b0, 1'b1);
      bus_cycle(1'b0, 1'b1, 8'h0F, 1'b0, 1'b1);
      check("R10 cancel keeps a", sel_a, 1);
      check("R10 cancel keeps c", sel_c, 0);
      // select volume 15 via 3Fh
      vsel(8'h3F);
      check("R5 a deselected", sel_a, 0);
      check("R3 c selected", sel_c, 1);
      check("R9 second pulse", chg_cnt, 2);
      bus_cycle(1'b1, 1'b0, 8'h90, 1'b0, 1'b0);
      // strap change after start-up has no effect
      strap_a = 4'd9;
      vsel(8'h09);
      check("R1 late strap ignored", sel_a, 0);
      vsel(8'h05);
      check("R1 original volume kept", sel_a, 1);
      check("R9 third pulse", chg_cnt, 3);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule